// File: doc/BRIEF.md
# Eight-Way Tag Lookup with SRAM Way Reservation

This block is the address-decode and tag-match front end of an eight-way set-associative on-chip array. A 36-bit physical address (bit 0 is the most significant, so address bit i sits at vector position 35-i) is cut into a tag, a bank select, a set index and a byte offset. In cache mode the block reads the eight stored entries of the indexed set, compares all of them with the request tag at once and returns hit or miss with the matching way. The stored key holds the bank bits as well as the tag, so two banks never alias.

A reservation setting hands the top ways of every set over to memory-mapped SRAM. An SRAM access does not consult the tags. Its way comes straight from three address bits, and it is refused if that way is not reserved. Reserved ways also drop out of cache matching and out of replacement.

Fills write a tag into the way chosen by a round-robin pointer that is kept per set. Results are registered and appear one cycle after the request strobe.

Top module: `l2_tag_lookup`

## Requirements
- R1: Address fields: tag = bits 0–19 (`req_pa[35:16]`), bank = bits 20–22 (`req_pa[15:13]`), set = bits 23–30 (`req_pa[12:5]`), offset = bits 31–35 (`req_pa[4:0]`). The response reports the bank, set and offset of the request.
- R2: A request sampled with `req_vld` high at a rising edge gives `rsp_vld` high for exactly the following cycle. The response fields hold their values until the next request.
- R3: After reset every valid bit and every replacement pointer is zero, so every cache lookup misses.
- R4: A cache lookup (`req_sram`=0) hits only when a valid, non-reserved way of the indexed set holds the same tag and the same bank. `rsp_way` gives that way.
- R5: When several ways match, the lowest way number is reported and `rsp_multi_hit` is 1. Otherwise it is 0.
- R6: A fill writes into the set's round-robin victim and marks it valid. The victim starts at way 0 and advances by one per fill, wrapping past the last non-reserved way. Each set has its own pointer.
- R7: `sram_mode` encodes the count of reserved ways as 0→none, 1→one, 2→two, 3→four, 4→all eight. Reserved ways are the highest-numbered ways. They never give a cache hit and are never chosen by a fill.
- R8: An SRAM access (`req_sram`=1) takes its way from address bits 17–19 (`req_pa[18:16]`) with no tag check. It gives `rsp_hit`=1 if that way is reserved. Otherwise it gives `rsp_hit`=0 and `rsp_sram_err`=1, with `rsp_way` still showing the selected way.
- R9: A lookup and a fill in the same cycle to the same set are both performed. The lookup sees the contents before the fill.
- R10: With all ways reserved, fills are ignored. The unused codes 5–7 of `sram_mode` act as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sram_mode | input | 3 | Reserved-way count code |
| req_vld | input | 1 | Lookup request strobe |
| req_sram | input | 1 | 1 = SRAM access, 0 = cache lookup |
| req_pa | input | 36 | Request physical address |
| fill_vld | input | 1 | Fill strobe |
| fill_pa | input | 36 | Fill physical address |
| rsp_vld | output | 1 | Response valid |
| rsp_hit | output | 1 | Hit |
| rsp_way | output | 3 | Selected way |
| rsp_multi_hit | output | 1 | More than one way matched |
| rsp_sram_err | output | 1 | SRAM access to a non-reserved way |
| rsp_bank | output | 3 | Bank select of the request |
| rsp_set | output | 8 | Set index of the request |
| rsp_off | output | 5 | Byte offset of the request |

## Verification
A lookup and a fill can arrive in the same cycle. The bench provokes this by strobing both in one cycle with the same address in an empty set. It expects a miss from that lookup, and a hit in way 0 from a repeat lookup one cycle later. The bench also layers reservation changes over sets that are already filled, to show that the same stored entries hit, miss or are skipped by the pointer depending only on the current code.

// File: rtl/l2tl_pkg.sv
package l2tl_pkg;
  localparam int PA_W   = 36;
  localparam int TAG_W  = 20;
  localparam int BANK_W = 3;
  localparam int SET_W  = 8;
  localparam int OFF_W  = 5;
  localparam int WAYS   = 8;
  localparam int WAY_W  = $clog2(WAYS);

  // reservation codes: count of top ways handed to SRAM
  typedef enum logic [2:0] {
    RSV_NONE = 3'd0,
    RSV_ONE  = 3'd1,
    RSV_TWO  = 3'd2,
    RSV_FOUR = 3'd3,
    RSV_ALL  = 3'd4
  } rsv_mode_e;

  // most significant field first, matching big-endian address numbering
  typedef struct packed {
    logic [TAG_W-1:0]  tag;
    logic [BANK_W-1:0] bank;
    logic [SET_W-1:0]  set;
    logic [OFF_W-1:0]  off;
  } pa_fields_t;

  function automatic logic [WAY_W:0] rsv_count(input logic [2:0] code);
    logic [WAY_W:0] n;
    case (code)
      RSV_ONE:  n = (WAY_W+1)'(1);
      RSV_TWO:  n = (WAY_W+1)'(2);
      RSV_FOUR: n = (WAY_W+1)'(4);
      RSV_ALL:  n = (WAY_W+1)'(WAYS);
      default:  n = '0;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/l2tl_tag_store.sv
module l2tl_tag_store #(
  parameter int SET_W = 8,
  parameter int WAYS  = 8,
  parameter int KEY_W = 23,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            rd_idx,
  output logic [WAYS-1:0][KEY_W-1:0]  rd_key,
  output logic [WAYS-1:0]             rd_vld,
  input  logic                        wr_en,
  input  logic [SET_W-1:0]            wr_idx,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [KEY_W-1:0]            wr_key
);
  logic [KEY_W-1:0] key_mem [SETS][WAYS];
  logic [WAYS-1:0]  vld_mem [SETS];
  logic [WAYS-1:0]  way_dec;

  always_comb begin
    way_dec = '0;
    way_dec[wr_way] = wr_en;
  end

  // key storage carries no reset: contents are qualified by valid bits
  always_ff @(posedge clk) begin
    for (int w = 0; w < WAYS; w++) begin
      if (way_dec[w]) key_mem[wr_idx][w] <= wr_key;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) vld_mem[s] <= '0;
    end else if (wr_en) begin
      vld_mem[wr_idx] <= vld_mem[wr_idx] | way_dec;
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_rd
    assign rd_key[w] = key_mem[rd_idx][w];
  end
  assign rd_vld = vld_mem[rd_idx];

  AST_FILL_MARKS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_mem[$past(wr_idx)][$past(wr_way)]); // R6
endmodule

// File: rtl/l2tl_way_match.sv
module l2tl_way_match #(
  parameter int WAYS  = 8,
  parameter int KEY_W = 23,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [KEY_W-1:0]            key,
  input  logic [WAYS-1:0][KEY_W-1:0]  stored,
  input  logic [WAYS-1:0]             vld,
  input  logic [WAYS-1:0]             excl,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic                        multi
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = vld[w] && !excl[w] && (stored[w] == key);
  end

  // scan downwards so the lowest matching way is the one kept
  always_comb begin
    hit_way = '0;
    for (int w = WAYS-1; w >= 0; w--) begin
      if (match[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit   = |match;
  assign multi = $countones(match) > 1;
endmodule

// File: rtl/l2tl_repl_ptr.sv
module l2tl_repl_ptr #(
  parameter int SET_W = 8,
  parameter int WAYS  = 8,
  localparam int SETS  = 1 << SET_W,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fill_req,
  input  logic [SET_W-1:0] fill_idx,
  input  logic [WAY_W:0]   limit,
  output logic             fill_ok,
  output logic [WAY_W-1:0] victim
);
  logic [WAY_W-1:0] ptr_mem [SETS];
  logic [WAY_W-1:0] cur_ptr;
  logic [WAY_W-1:0] nxt_ptr;
  logic [WAY_W:0]   vic_p1;

  always_comb begin
    cur_ptr = ptr_mem[fill_idx];
    victim  = ({1'b0, cur_ptr} >= limit) ? '0 : cur_ptr;
    vic_p1  = {1'b0, victim} + 1'b1;
    nxt_ptr = (vic_p1 >= limit) ? '0 : vic_p1[WAY_W-1:0];
    fill_ok = fill_req && (limit != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) ptr_mem[s] <= '0;
    end else if (fill_ok) begin
      ptr_mem[fill_idx] <= nxt_ptr;
    end
  end

  AST_VICTIM_UNRESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ok |-> ({1'b0, victim} < limit)); // R7
endmodule

// File: rtl/l2_tag_lookup.sv
module l2_tag_lookup
  import l2tl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        sram_mode,
  input  logic              req_vld,
  input  logic              req_sram,
  input  logic [PA_W-1:0]   req_pa,
  input  logic              fill_vld,
  input  logic [PA_W-1:0]   fill_pa,
  output logic              rsp_vld,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_multi_hit,
  output logic              rsp_sram_err,
  output logic [BANK_W-1:0] rsp_bank,
  output logic [SET_W-1:0]  rsp_set,
  output logic [OFF_W-1:0]  rsp_off
);
  localparam int KEY_W = TAG_W + BANK_W;
  localparam int LIM_W = WAY_W + 1;

  pa_fields_t req_f;
  pa_fields_t fill_f;
  logic [KEY_W-1:0]           req_key;
  logic [KEY_W-1:0]           fill_key;
  logic [LIM_W-1:0]           limit;
  logic [WAYS-1:0]            excl;
  logic [WAYS-1:0][KEY_W-1:0] set_keys;
  logic [WAYS-1:0]            set_vld;
  logic                       c_hit;
  logic [WAY_W-1:0]           c_way;
  logic                       c_multi;
  logic                       fill_ok;
  logic [WAY_W-1:0]           victim;
  logic [WAY_W-1:0]           sram_way;
  logic                       unused_fill_off;

  assign req_f    = pa_fields_t'(req_pa);
  assign fill_f   = pa_fields_t'(fill_pa);
  assign req_key  = {req_f.tag, req_f.bank};
  assign fill_key = {fill_f.tag, fill_f.bank};
  assign sram_way = req_f.tag[WAY_W-1:0];
  assign unused_fill_off = ^fill_f.off;

  assign limit = LIM_W'(WAYS) - rsv_count(sram_mode);

  for (genvar w = 0; w < WAYS; w++) begin : g_excl
    assign excl[w] = (LIM_W'(w) >= limit);
  end

  l2tl_tag_store #(.SET_W(SET_W), .WAYS(WAYS), .KEY_W(KEY_W)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (req_f.set),
    .rd_key (set_keys),
    .rd_vld (set_vld),
    .wr_en  (fill_ok),
    .wr_idx (fill_f.set),
    .wr_way (victim),
    .wr_key (fill_key)
  );

  l2tl_way_match #(.WAYS(WAYS), .KEY_W(KEY_W)) u_match (
    .key     (req_key),
    .stored  (set_keys),
    .vld     (set_vld),
    .excl    (excl),
    .hit     (c_hit),
    .hit_way (c_way),
    .multi   (c_multi)
  );

  l2tl_repl_ptr #(.SET_W(SET_W), .WAYS(WAYS)) u_repl (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_req (fill_vld),
    .fill_idx (fill_f.set),
    .limit    (limit),
    .fill_ok  (fill_ok),
    .victim   (victim)
  );

  // next-state of the response
  logic             hit_n, multi_n, err_n;
  logic [WAY_W-1:0] way_n;

  always_comb begin
    if (req_sram) begin
      way_n   = sram_way;
      hit_n   = excl[sram_way];
      err_n   = !excl[sram_way];
      multi_n = 1'b0;
    end else begin
      way_n   = c_way;
      hit_n   = c_hit;
      err_n   = 1'b0;
      multi_n = c_multi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_vld <= 1'b0;
    end else begin
      rsp_vld <= req_vld;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_hit       <= 1'b0;
      rsp_way       <= '0;
      rsp_multi_hit <= 1'b0;
      rsp_sram_err  <= 1'b0;
      rsp_bank      <= '0;
      rsp_set       <= '0;
      rsp_off       <= '0;
    end else if (req_vld) begin
      rsp_hit       <= hit_n;
      rsp_way       <= way_n;
      rsp_multi_hit <= multi_n;
      rsp_sram_err  <= err_n;
      rsp_bank      <= req_f.bank;
      rsp_set       <= req_f.set;
      rsp_off       <= req_f.off;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_vld |=> rsp_vld); // R2
  AST_RSP_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> $past(req_vld)); // R2
  AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !req_vld |=> ($stable(rsp_way) && $stable(rsp_set) && $stable(rsp_hit))); // R2
  AST_SRAM_ERR_NO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_sram_err) |-> !rsp_hit); // R8
  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_vld && rsp_multi_hit) |-> (rsp_hit && !rsp_sram_err)); // R5
  AST_CACHE_HIT_UNRESERVED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_vld && !req_sram && c_hit) |-> !excl[c_way]); // R7
endmodule

// File: tb/l2_tag_lookup_tb_top.sv
module l2_tag_lookup_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  sram_mode;
  logic        req_vld, req_sram, fill_vld;
  logic [35:0] req_pa, fill_pa;
  logic        rsp_vld, rsp_hit, rsp_multi_hit, rsp_sram_err;
  logic [2:0]  rsp_way, rsp_bank;
  logic [7:0]  rsp_set;
  logic [4:0]  rsp_off;

  int n_chk = 0;
  int n_err = 0;

  always #10 clk = ~clk; // 50 MHz

  l2_tag_lookup dut_i (
    .clk(clk), .rst_n(rst_n), .sram_mode(sram_mode),
    .req_vld(req_vld), .req_sram(req_sram), .req_pa(req_pa),
    .fill_vld(fill_vld), .fill_pa(fill_pa),
    .rsp_vld(rsp_vld), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_multi_hit(rsp_multi_hit), .rsp_sram_err(rsp_sram_err),
    .rsp_bank(rsp_bank), .rsp_set(rsp_set), .rsp_off(rsp_off)
  );

  function automatic logic [35:0] mk(input logic [19:0] t, input logic [2:0] b,
                                     input logic [7:0] s, input logic [4:0] o);
    return {t, b, s, o};
  endfunction

  task automatic check(input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic set_mode(input logic [2:0] m);
    @(negedge clk);
    sram_mode = m;
  endtask

  task automatic lookup(input logic [35:0] pa, input logic sram);
    @(negedge clk);
    req_pa = pa; req_sram = sram; req_vld = 1'b1;
    @(posedge clk); #2;
    req_vld = 1'b0;
  endtask

  task automatic fill(input logic [35:0] pa);
    @(negedge clk);
    fill_pa = pa; fill_vld = 1'b1;
    @(posedge clk); #2;
    fill_vld = 1'b0;
  endtask

  task automatic expect_cache(input string rq, input logic [35:0] pa,
                              input logic hit, input logic [2:0] way, input logic multi);
    lookup(pa, 1'b0);
    check(rq, "rsp_vld", rsp_vld, 1);
    check(rq, "hit", rsp_hit, hit);
    if (hit) check(rq, "way", rsp_way, way);
    check(rq, "multi", rsp_multi_hit, multi);
    check(rq, "sram_err", rsp_sram_err, 0);
  endtask

  task automatic t_reset();
    check("R3", "rsp_vld after reset", rsp_vld, 0);
    expect_cache("R3", mk(20'h12345, 3'd2, 8'h10, 5'd0), 0, 0, 0);
    expect_cache("R3", mk(20'h00000, 3'd0, 8'h00, 5'd0), 0, 0, 0);
  endtask

  task automatic t_fields();
    lookup(mk(20'hABCDE, 3'd5, 8'h3C, 5'd17), 1'b0);
    check("R1", "bank", rsp_bank, 3'd5);
    check("R1", "set", rsp_set, 8'h3C);
    check("R1", "off", rsp_off, 5'd17);
  endtask

  task automatic t_hold();
    lookup(mk(20'h11111, 3'd1, 8'h22, 5'd9), 1'b0);
    @(posedge clk); #2;
    check("R2", "rsp_vld drops", rsp_vld, 0);
    check("R2", "set held", rsp_set, 8'h22);
    check("R2", "off held", rsp_off, 5'd9);
  endtask

  task automatic t_basic_hit();
    fill(mk(20'h12345, 3'd2, 8'h10, 5'd0));
    fill(mk(20'h54321, 3'd2, 8'h10, 5'd0));
    expect_cache("R4", mk(20'h12345, 3'd2, 8'h10, 5'd3), 1, 3'd0, 0);
    expect_cache("R6", mk(20'h54321, 3'd2, 8'h10, 5'd0), 1, 3'd1, 0);
    expect_cache("R4", mk(20'h12345, 3'd3, 8'h10, 5'd0), 0, 0, 0);
    expect_cache("R4", mk(20'h12345, 3'd2, 8'h11, 5'd0), 0, 0, 0);
  endtask

  task automatic t_multi();
    fill(mk(20'h12345, 3'd2, 8'h10, 5'd0));
    expect_cache("R5", mk(20'h12345, 3'd2, 8'h10, 5'd0), 1, 3'd0, 1);
    expect_cache("R5", mk(20'h54321, 3'd2, 8'h10, 5'd0), 1, 3'd1, 0);
  endtask

  task automatic t_per_set();
    fill(mk(20'h77777, 3'd0, 8'h20, 5'd0));
    expect_cache("R6", mk(20'h77777, 3'd0, 8'h20, 5'd0), 1, 3'd0, 0);
  endtask

  task automatic t_reserve();
    for (int i = 0; i < 8; i++) fill(mk(20'h0A000 + 20'(i), 3'd0, 8'h40, 5'd0));
    expect_cache("R6", mk(20'h0A007, 3'd0, 8'h40, 5'd0), 1, 3'd7, 0);
    set_mode(3'd1);
    expect_cache("R7", mk(20'h0A007, 3'd0, 8'h40, 5'd0), 0, 0, 0);
    expect_cache("R7", mk(20'h0A000, 3'd0, 8'h40, 5'd0), 1, 3'd0, 0);
    set_mode(3'd2);
    for (int i = 0; i < 7; i++) fill(mk(20'h0B000 + 20'(i), 3'd0, 8'h30, 5'd0));
    expect_cache("R7", mk(20'h0B006, 3'd0, 8'h30, 5'd0), 1, 3'd0, 0);
    expect_cache("R7", mk(20'h0B005, 3'd0, 8'h30, 5'd0), 1, 3'd5, 0);
    expect_cache("R6", mk(20'h0B000, 3'd0, 8'h30, 5'd0), 0, 0, 0);
  endtask

  task automatic t_sram();
    set_mode(3'd3);
    lookup(mk(20'hFFFF5, 3'd0, 8'h31, 5'd0), 1'b1);
    check("R8", "sram hit", rsp_hit, 1);
    check("R8", "sram way", rsp_way, 3'd5);
    check("R8", "sram err", rsp_sram_err, 0);
    lookup(mk(20'hFFFF2, 3'd0, 8'h31, 5'd0), 1'b1);
    check("R8", "sram bad hit", rsp_hit, 0);
    check("R8", "sram bad err", rsp_sram_err, 1);
    check("R8", "sram bad way", rsp_way, 3'd2);
    set_mode(3'd0);
    lookup(mk(20'h00007, 3'd0, 8'h31, 5'd0), 1'b1);
    check("R8", "no reservation err", rsp_sram_err, 1);
    check("R8", "no reservation hit", rsp_hit, 0);
  endtask

  task automatic t_all_and_bad_codes();
    set_mode(3'd4);
    fill(mk(20'h0C000, 3'd0, 8'h50, 5'd0));
    lookup(mk(20'h0C000, 3'd0, 8'h50, 5'd0), 1'b1);
    check("R10", "all reserved sram hit", rsp_hit, 1);
    check("R10", "all reserved sram way", rsp_way, 3'd0);
    set_mode(3'd0);
    expect_cache("R10", mk(20'h0C000, 3'd0, 8'h50, 5'd0), 0, 0, 0);
    set_mode(3'd5);
    expect_cache("R10", mk(20'h0A007, 3'd0, 8'h40, 5'd0), 1, 3'd7, 0);
    set_mode(3'd0);
  endtask

  task automatic t_same_cycle();
    @(negedge clk);
    req_pa = mk(20'h0D000, 3'd1, 8'h60, 5'd0); req_sram = 1'b0; req_vld = 1'b1;
    fill_pa = mk(20'h0D000, 3'd1, 8'h60, 5'd0); fill_vld = 1'b1;
    @(posedge clk); #2;
    req_vld = 1'b0; fill_vld = 1'b0;
    check("R9", "lookup sees pre-fill", rsp_hit, 0);
    expect_cache("R9", mk(20'h0D000, 3'd1, 8'h60, 5'd0), 1, 3'd0, 0);
  endtask

  initial begin
    #2000000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sram_mode = 3'd0;
    req_vld = 1'b0; req_sram = 1'b0; req_pa = '0;
    fill_vld = 1'b0; fill_pa = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_hold();
    t_basic_hit();
    t_multi();
    t_per_set();
    t_reserve();
    t_sram();
    t_all_and_bad_codes();
    t_same_cycle();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule